// File: doc/BRIEF.md
# Two-Dollar Coin Vending Controller

This block is the decision core of a machine that sells a single item for two dollars. Each clock cycle it sees at most one coin: one, two or five dollars, or no coin. The only credit it keeps from one cycle to the next is whether one dollar has already been paid. It therefore has two states: no credit, and one dollar held.

The outputs are Mealy outputs. In the cycle in which the paid amount reaches or passes the price, the block raises a dispense flag and reports the change owed, both in that same cycle. The state then returns to no credit. The item supply is treated as endless. Checking that a coin is genuine and paying change out physically are handled by logic outside this block.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_ni` is low the state is forced to no credit. After release, a single one-dollar coin (code 01) gives `vend_o` = 000.
- R2: With coin code 00 (no coin), `vend_o` is 000 and the held credit is unchanged, so a later one-dollar coin still completes a pending sale.
- R3: A one-dollar coin with no credit held gives `vend_o` = 000 and holds one dollar of credit.
- R4: A one-dollar coin with one dollar held gives `vend_o` = 001: bit 0 dispenses, and bits 2:1 = 00 mean no change.
- R5: A two-dollar coin (code 10) with one dollar held gives `vend_o` = 011: dispense, with change code 01 meaning one dollar.
- R6: A five-dollar coin (code 11) with one dollar held gives `vend_o` = 111: dispense, with change code 11 meaning four dollars.
- R7: A two-dollar coin with no credit held gives `vend_o` = 001.
- R8: A five-dollar coin with no credit held gives `vend_o` = 101: dispense, with change code 10 meaning three dollars.
- R9: Every dispense leaves no credit held, so a one-dollar coin in the next cycle gives 000.
- R10: Pulling `rst_ni` low while one dollar is held clears that credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin_i | input | 2 | Coin code: 00 none, 01 one dollar, 10 two dollars, 11 five dollars |
| vend_o | output | 3 | Bit 0 dispense; bits 2:1 change code (00 none, 01 one dollar, 10 three dollars, 11 four dollars) |

## Verification
The bench builds the block with its default parameters: a price of two and coin values of one, two and five. These defaults make every change amount the block can produce (one, three and four dollars) reachable from the two states. The bench drives each coin from each state and holds credit across runs of no-coin cycles. It also checks that a dispense always leaves no credit held, and applies reset while credit is pending.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    COIN_NONE = 2'b00,
    COIN_ONE  = 2'b01,
    COIN_TWO  = 2'b10,
    COIN_FIVE = 2'b11
  } coin_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } vend_state_e;

  typedef enum logic [1:0] {
    CHG_NONE  = 2'b00,
    CHG_ONE   = 2'b01,
    CHG_THREE = 2'b10,
    CHG_FOUR  = 2'b11
  } chg_e;
endpackage

// File: rtl/vend_coin_dec.sv
module vend_coin_dec #(
  parameter int VAL_SMALL = 1,
  parameter int VAL_MID   = 2,
  parameter int VAL_BIG   = 5,
  parameter int VAL_W     = 4
) (
  input  vend_pkg::coin_e   coin_i,
  output logic [VAL_W-1:0]  val_o
);
  import vend_pkg::*;

  always_comb begin
    unique case (coin_i)
      COIN_ONE:  val_o = VAL_W'(VAL_SMALL);
      COIN_TWO:  val_o = VAL_W'(VAL_MID);
      COIN_FIVE: val_o = VAL_W'(VAL_BIG);
      default:   val_o = '0;
    endcase
  end
endmodule

// File: rtl/vend_credit_calc.sv
module vend_credit_calc #(
  parameter int PRICE     = 2,
  parameter int VAL_SMALL = 1,
  parameter int VAL_W     = 4
) (
  input  vend_pkg::vend_state_e state_i,
  input  logic [VAL_W-1:0]      val_i,
  output logic                  dispense_o,
  output logic [VAL_W-1:0]      excess_o,
  output vend_pkg::vend_state_e state_no
);
  import vend_pkg::*;

  logic [VAL_W-1:0] total;

  always_comb begin
    total      = ((state_i == ST_HELD) ? VAL_W'(VAL_SMALL) : '0) + val_i;
    dispense_o = (total >= VAL_W'(PRICE));
    excess_o   = dispense_o ? (total - VAL_W'(PRICE)) : '0;
    if (dispense_o)        state_no = ST_IDLE;
    else if (val_i != '0)  state_no = ST_HELD;
    else                   state_no = state_i;
  end
endmodule

// File: rtl/vend_chg_enc.sv
module vend_chg_enc #(
  parameter int PRICE     = 2,
  parameter int VAL_SMALL = 1,
  parameter int VAL_MID   = 2,
  parameter int VAL_BIG   = 5,
  parameter int VAL_W     = 4
) (
  input  logic [VAL_W-1:0] excess_i,
  output vend_pkg::chg_e   chg_o
);
  import vend_pkg::*;

  localparam logic [VAL_W-1:0] EX_HELD_MID = VAL_W'(VAL_SMALL + VAL_MID - PRICE);
  localparam logic [VAL_W-1:0] EX_IDLE_BIG = VAL_W'(VAL_BIG - PRICE);
  localparam logic [VAL_W-1:0] EX_HELD_BIG = VAL_W'(VAL_SMALL + VAL_BIG - PRICE);

  always_comb begin
    if (excess_i == '0)               chg_o = CHG_NONE;
    else if (excess_i == EX_HELD_MID) chg_o = CHG_ONE;
    else if (excess_i == EX_IDLE_BIG) chg_o = CHG_THREE;
    else if (excess_i == EX_HELD_BIG) chg_o = CHG_FOUR;
    else                              chg_o = CHG_NONE;
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int PRICE     = 2,
  parameter int VAL_SMALL = 1,
  parameter int VAL_MID   = 2,
  parameter int VAL_BIG   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] coin_i,
  output logic [2:0] vend_o
);
  import vend_pkg::*;

  localparam int VAL_W = $clog2(VAL_SMALL + VAL_BIG + 1) + 1;

  vend_state_e      state_q, state_d;
  logic [VAL_W-1:0] coin_val;
  logic [VAL_W-1:0] excess;
  logic             dispense;
  chg_e             chg;

  vend_coin_dec #(
    .VAL_SMALL(VAL_SMALL), .VAL_MID(VAL_MID), .VAL_BIG(VAL_BIG), .VAL_W(VAL_W)
  ) u_dec (
    .coin_i (coin_e'(coin_i)),
    .val_o  (coin_val)
  );

  vend_credit_calc #(
    .PRICE(PRICE), .VAL_SMALL(VAL_SMALL), .VAL_W(VAL_W)
  ) u_calc (
    .state_i    (state_q),
    .val_i      (coin_val),
    .dispense_o (dispense),
    .excess_o   (excess),
    .state_no   (state_d)
  );

  vend_chg_enc #(
    .PRICE(PRICE), .VAL_SMALL(VAL_SMALL), .VAL_MID(VAL_MID), .VAL_BIG(VAL_BIG),
    .VAL_W(VAL_W)
  ) u_enc (
    .excess_i (excess),
    .chg_o    (chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign vend_o = {chg, dispense};
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            coin_i,
  input logic [2:0]            vend_o,
  input vend_pkg::vend_state_e state_q
);
  import vend_pkg::*;

  // R2
  no_coin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_i == 2'b00 |-> vend_o == 3'b000);
  // R2
  no_coin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coin_i == 2'b00 |=> $stable(state_q));
  // R3
  first_dollar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && coin_i == 2'b01) |-> (vend_o == 3'b000 ##1 state_q == ST_HELD));
  // R4
  two_singles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && coin_i == 2'b01) |-> vend_o == 3'b001);
  // R5
  held_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && coin_i == 2'b10) |-> vend_o == 3'b011);
  // R6
  held_big_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && coin_i == 2'b11) |-> vend_o == 3'b111);
  // R7
  idle_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && coin_i == 2'b10) |-> vend_o == 3'b001);
  // R8
  idle_big_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && coin_i == 2'b11) |-> vend_o == 3'b101);
  // R9
  dispense_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_o[0] |=> (coin_i != 2'b01 || vend_o == 3'b000));
endmodule

bind vend_ctrl vend_ctrl_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .coin_i  (coin_i),
  .vend_o  (vend_o),
  .state_q (state_q)
);

// File: tb/vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module vend_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] coin_i = 2'b00;
  logic [2:0] vend_o;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #5 clk_i = ~clk_i;

  vend_ctrl dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .coin_i (coin_i),
    .vend_o (vend_o)
  );

  task automatic check(input logic [2:0] exp, input string req);
    n_chk++;
    if (vend_o !== exp) begin
      n_err++;
      $display("FAIL %s: vend_o=%b expected=%b", req, vend_o, exp);
    end
  endtask

  task automatic step(input logic [1:0] coin, input logic [2:0] exp, input string req);
    @(negedge clk_i);
    coin_i = coin;
    #1;
    check(exp, req);
  endtask

  task automatic t_reset;
    coin_i = 2'b00;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    #1 check(3'b000, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(2'b01, 3'b000, "R1");
    step(2'b01, 3'b001, "R4");
    step(2'b00, 3'b000, "R2");
  endtask

  task automatic t_no_coin;
    step(2'b00, 3'b000, "R2");
    step(2'b01, 3'b000, "R3");
    for (int i = 0; i < 4; i++) step(2'b00, 3'b000, "R2");
    step(2'b01, 3'b001, "R2");
  endtask

  task automatic t_one_one;
    step(2'b01, 3'b000, "R3");
    step(2'b01, 3'b001, "R4");
  endtask

  task automatic t_one_two;
    step(2'b01, 3'b000, "R3");
    step(2'b10, 3'b011, "R5");
  endtask

  task automatic t_one_five;
    step(2'b01, 3'b000, "R3");
    step(2'b11, 3'b111, "R6");
  endtask

  task automatic t_two;
    step(2'b10, 3'b001, "R7");
    step(2'b10, 3'b001, "R7");
  endtask

  task automatic t_five;
    step(2'b11, 3'b101, "R8");
    step(2'b11, 3'b101, "R8");
  endtask

  task automatic t_back_to_idle;
    step(2'b11, 3'b101, "R8");
    step(2'b01, 3'b000, "R9");
    step(2'b10, 3'b011, "R5");
    step(2'b01, 3'b000, "R9");
    step(2'b01, 3'b001, "R4");
    step(2'b01, 3'b000, "R9");
    step(2'b11, 3'b111, "R6");
    step(2'b01, 3'b000, "R9");
    step(2'b00, 3'b000, "R2");
    step(2'b01, 3'b001, "R9");
  endtask

  task automatic t_reset_clears;
    step(2'b01, 3'b000, "R3");
    @(negedge clk_i);
    coin_i = 2'b00;
    rst_ni = 1'b0;
    #1 check(3'b000, "R10");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(2'b01, 3'b000, "R10");
    step(2'b10, 3'b011, "R10");
  endtask

  initial begin
    t_reset();
    t_no_coin();
    t_one_one();
    t_one_two();
    t_one_five();
    t_two();
    t_five();
    t_back_to_idle();
    t_reset_clears();
    step(2'b00, 3'b000, "R2");
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule